// File: doc/BRIEF.md
# Banked Cartridge Mapper with Latched Clock

This block sits between a CPU bus and a cartridge's ROM and RAM arrays. Control writes to the ROM address space select a switchable ROM bank. They also select what the external RAM window shows, which is either one of several RAM banks or one of five clock registers. Further control writes enable external access and take a snapshot of the time. The block turns each CPU address into a banked ROM address and a banked RAM address. It asserts a RAM chip select only when the window is showing a RAM bank.

A built-in time-of-day counter advances on a one-pulse-per-second input. It holds seconds, minutes, hours and a 9-bit day count, and a control byte that carries day bit 8, a halt flag and a sticky day-overflow flag. Software freezes a consistent copy of the counter by writing 0 and then 1 to the latch register. While the stored latch value is nonzero, clock reads return that frozen copy. Clock writes always go to the running counter.

Top module: `cart_bank_rtc`

## Requirements
- R1: A write to 0x2000–0x3FFF loads the ROM bank from data bits 6:0. Data bit 7 is ignored, and a result of 0 is stored as bank 1. The bank after reset is 1.
- R2: For CPU addresses 0x0000–0x3FFF, rom_addr equals the address. For 0x4000–0x7FFF, rom_addr is {bank, address[13:0]}, which equals (address − 0x4000) + bank × 0x4000.
- R3: A write of 0x00–0x03 to 0x4000–0x5FFF makes the window show that RAM bank. A write of 0x08–0x0C makes it show clock register (value − 0x08). Any other value leaves the selection unchanged.
- R4: ram_addr is {RAM bank, address[12:0]}. ram_cs is 1 when access is enabled, a RAM bank is selected, the address is in 0xA000–0xBFFF and a read or write strobe is high. ram_we is ram_cs qualified by the write strobe.
- R5: A write to 0x0000–0x1FFF enables access when data bits 3:0 equal 0xA and disables it otherwise. While access is disabled, ram_cs and rtc_hit stay 0 and clock writes are ignored. Access is disabled after reset.
- R6: A write to 0x6000–0x7FFF stores its data as the latch value. The live clock is copied into the snapshot only when the old latch value was 0x00 and the new data is 0x01.
- R7: A read of 0xA000–0xBFFF with a clock register selected raises rtc_hit. It returns the snapshot while the latch value is nonzero, and the live register otherwise. The register layout is: 0 = seconds in bits 5:0, 1 = minutes in bits 5:0, 2 = hours in bits 4:0, 3 = day bits 7:0, 4 = control with bit 0 holding day bit 8, bit 6 the halt flag and bit 7 the carry flag. All other bits read 0.
- R8: A write to 0xA000–0xBFFF with a clock register selected and access enabled updates the live register.
- R9: Each tick advances the time. Seconds wrap after 59 into minutes, minutes wrap after 59 into hours, and hours wrap after 23 into the day count.
- R10: While the halt flag is 1, ticks leave the time unchanged.
- R11: When the day count advances past 511 it becomes 0 and the carry flag is set. The carry flag stays set until software writes the control register with bit 7 clear.
- R12: Reset clears the time, the snapshot, the latch value and the selection. After reset the window shows RAM bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| sec_tick | input | 1 | One-cycle pulse once per second |
| rom_addr | output | ROM_BANK_W+14 | Banked ROM array address |
| ram_addr | output | RAM_BANK_W+13 | Banked RAM array address |
| ram_cs | output | 1 | RAM array select |
| ram_we | output | 1 | RAM array write enable |
| rtc_hit | output | 1 | Read data is a clock register |
| rtc_rdata | output | 8 | Clock register read data, 0 when rtc_hit is low |

## Verification
On every cycle, the assertions check the time counter and the ROM bank register. A zero bank write lands as bank 1. The seconds field and the day count wrap after their last value. A halted counter holds still. The carry flag is not lost until the control register is written. The snapshot never moves except on a 0→1 latch write. The bench scenarios are the only place where the address mapping, the rejection of bad select values, the enable gating, and the choice between snapshot and live data on reads can be seen at the ports. The same holds for the full cascade from seconds to the day count.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

   // Bus windows decoded from address bits 15:13
   localparam logic [2:0] WIN_ENABLE = 3'd0;
   localparam logic [2:0] WIN_ROMSEL = 3'd1;
   localparam logic [2:0] WIN_SELECT = 3'd2;
   localparam logic [2:0] WIN_LATCH  = 3'd3;
   localparam logic [2:0] WIN_EXT    = 3'd5;

   localparam int ROM_OFS_W = 14;
   localparam int RAM_OFS_W = 13;

   localparam int SECS_PER_MIN = 60;
   localparam int MINS_PER_HR  = 60;
   localparam int HRS_PER_DAY  = 24;

   localparam int SEC_W = $clog2(SECS_PER_MIN);
   localparam int MIN_W = $clog2(MINS_PER_HR);
   localparam int HR_W  = $clog2(HRS_PER_DAY);
   localparam int DAY_W = 9;

   localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SECS_PER_MIN - 1);
   localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MINS_PER_HR - 1);
   localparam logic [HR_W-1:0]  HR_LAST  = HR_W'(HRS_PER_DAY - 1);

   localparam int CLK_REGS  = 5;
   localparam int CLK_IDX_W = $clog2(CLK_REGS);

   typedef enum logic {SEL_RAM = 1'b0, SEL_CLK = 1'b1} win_kind_e;

   typedef struct packed {
      logic             carry;
      logic             halt;
      logic [DAY_W-1:0] day;
      logic [HR_W-1:0]  hr;
      logic [MIN_W-1:0] min;
      logic [SEC_W-1:0] sec;
   } clk_time_t;

   typedef logic [CLK_REGS-1:0][7:0] clk_view_t;

   function automatic clk_view_t time_view(clk_time_t t);
      clk_view_t v;
      v[0] = 8'(t.sec);
      v[1] = 8'(t.min);
      v[2] = 8'(t.hr);
      v[3] = t.day[7:0];
      v[4] = {t.carry, t.halt, 5'b00000, t.day[DAY_W-1]};
      return v;
   endfunction

endpackage

// File: rtl/cbr_ctl.sv
module cbr_ctl
   import cbr_pkg::*;
#(
   parameter int ROM_BANK_W = 7,
   parameter int RAM_BANK_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [15:0]           addr,
   input  logic [7:0]            wdata,
   input  logic                  wr,
   output logic [ROM_BANK_W-1:0] rom_bank,
   output logic [RAM_BANK_W-1:0] ram_bank,
   output win_kind_e             kind,
   output logic [CLK_IDX_W-1:0]  clk_idx,
   output logic                  access_en,
   output logic                  latched,
   output logic                  latch_go,
   output logic                  clk_wr
);

   logic [2:0]            win;
   logic [ROM_BANK_W-1:0] rom_req;
   logic [7:0]            latch_q;

   assign win     = addr[15:13];
   assign rom_req = wdata[ROM_BANK_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rom_bank  <= ROM_BANK_W'(1);
         ram_bank  <= '0;
         kind      <= SEL_RAM;
         clk_idx   <= '0;
         access_en <= 1'b0;
         latch_q   <= 8'h00;
      end else if (wr) begin
         case (win)
            WIN_ENABLE: access_en <= (wdata[3:0] == 4'hA);
            WIN_ROMSEL: rom_bank  <= (rom_req == '0) ? ROM_BANK_W'(1) : rom_req;
            WIN_SELECT: begin
               if (wdata <= 8'h03) begin
                  kind     <= SEL_RAM;
                  ram_bank <= wdata[RAM_BANK_W-1:0];
               end else if (wdata >= 8'h08 && wdata <= 8'h0C) begin
                  kind    <= SEL_CLK;
                  clk_idx <= wdata[CLK_IDX_W-1:0];
               end
            end
            WIN_LATCH:  latch_q <= wdata;
            default: ;
         endcase
      end
   end

   assign latched  = (latch_q != 8'h00);
   assign latch_go = wr && (win == WIN_LATCH) && (latch_q == 8'h00) && (wdata == 8'h01);
   assign clk_wr   = wr && (win == WIN_EXT) && access_en && (kind == SEL_CLK);

   p_zero_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && win == WIN_ROMSEL && wdata[6:0] == 7'h00) |=> (rom_bank == ROM_BANK_W'(1)));

endmodule

// File: rtl/cbr_clock.sv
module cbr_clock
   import cbr_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 clk_wr,
   input  logic [CLK_IDX_W-1:0] wr_idx,
   input  logic [7:0]           wdata,
   input  logic                 latch_go,
   output clk_view_t            live_view,
   output clk_view_t            snap_view
);

   clk_time_t live_q;
   clk_time_t nxt;

   always_comb begin
      nxt = live_q;
      if (live_q.sec >= SEC_LAST) begin
         nxt.sec = '0;
         if (live_q.min >= MIN_LAST) begin
            nxt.min = '0;
            if (live_q.hr >= HR_LAST) begin
               nxt.hr = '0;
               if (&live_q.day) begin
                  nxt.day   = '0;
                  nxt.carry = 1'b1;
               end else begin
                  nxt.day = live_q.day + 1'b1;
               end
            end else begin
               nxt.hr = live_q.hr + 1'b1;
            end
         end else begin
            nxt.min = live_q.min + 1'b1;
         end
      end else begin
         nxt.sec = live_q.sec + 1'b1;
      end
   end

   // A CPU write to the clock wins over a tick in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0;
      end else if (clk_wr) begin
         case (wr_idx)
            3'd0: live_q.sec <= wdata[SEC_W-1:0];
            3'd1: live_q.min <= wdata[MIN_W-1:0];
            3'd2: live_q.hr  <= wdata[HR_W-1:0];
            3'd3: live_q.day[7:0] <= wdata;
            3'd4: begin
               live_q.day[DAY_W-1] <= wdata[0];
               live_q.halt         <= wdata[6];
               live_q.carry        <= wdata[7];
            end
            default: ;
         endcase
      end else if (tick && !live_q.halt) begin
         live_q <= nxt;
      end
   end

   assign live_view = time_view(live_q);

   logic [7:0] snap_q [CLK_REGS];

   for (genvar g = 0; g < CLK_REGS; g++) begin : g_snap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        snap_q[g] <= 8'h00;
         else if (latch_go) snap_q[g] <= live_view[g];
      end
      assign snap_view[g] = snap_q[g];

      p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !latch_go |=> $stable(snap_q[g]));
   end

   p_sec_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clk_wr && !live_q.halt && live_q.sec == SEC_LAST) |=> (live_q.sec == '0));

   p_halt_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q.halt && !clk_wr) |=> $stable(live_q));

   p_day_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clk_wr && !live_q.halt && live_q.sec == SEC_LAST && live_q.min == MIN_LAST
       && live_q.hr == HR_LAST && (&live_q.day)) |=> (live_q.carry && live_q.day == '0));

   p_carry_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q.carry && !(clk_wr && wr_idx == 3'd4)) |=> live_q.carry);

endmodule

// File: rtl/cbr_map.sv
module cbr_map
   import cbr_pkg::*;
#(
   parameter int ROM_BANK_W = 7,
   parameter int RAM_BANK_W = 2
) (
   input  logic [15:0]                     addr,
   input  logic                            rd,
   input  logic                            wr,
   input  logic [ROM_BANK_W-1:0]           rom_bank,
   input  logic [RAM_BANK_W-1:0]           ram_bank,
   input  win_kind_e                       kind,
   input  logic [CLK_IDX_W-1:0]            clk_idx,
   input  logic                            access_en,
   input  logic                            latched,
   input  clk_view_t                       live_view,
   input  clk_view_t                       snap_view,
   output logic [ROM_BANK_W+ROM_OFS_W-1:0] rom_addr,
   output logic [RAM_BANK_W+RAM_OFS_W-1:0] ram_addr,
   output logic                            ram_cs,
   output logic                            ram_we,
   output logic                            rtc_hit,
   output logic [7:0]                      rtc_rdata
);

   logic       in_ext;
   logic [7:0] reg_val;

   assign in_ext   = (addr[15:13] == WIN_EXT);
   assign rom_addr = {({ROM_BANK_W{addr[14]}} & rom_bank), addr[ROM_OFS_W-1:0]};
   assign ram_addr = {ram_bank, addr[RAM_OFS_W-1:0]};

   assign ram_cs = in_ext && access_en && (kind == SEL_RAM) && (rd || wr);
   assign ram_we = ram_cs && wr;

   always_comb begin
      reg_val = 8'h00;
      if (32'(clk_idx) < CLK_REGS)
         reg_val = latched ? snap_view[clk_idx] : live_view[clk_idx];
   end

   assign rtc_hit   = in_ext && access_en && (kind == SEL_CLK) && rd;
   assign rtc_rdata = rtc_hit ? reg_val : 8'h00;

endmodule

// File: rtl/cart_bank_rtc.sv
module cart_bank_rtc
   import cbr_pkg::*;
#(
   parameter int ROM_BANK_W = 7,
   parameter int RAM_BANK_W = 2,
   localparam int ROM_AW = ROM_BANK_W + ROM_OFS_W,
   localparam int RAM_AW = RAM_BANK_W + RAM_OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              sec_tick,
   output logic [ROM_AW-1:0] rom_addr,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              ram_cs,
   output logic              ram_we,
   output logic              rtc_hit,
   output logic [7:0]        rtc_rdata
);

   if (ROM_BANK_W < 1 || ROM_BANK_W > 7) begin : g_bad_rom_w
      $error("ROM_BANK_W must lie in 1..7");
   end
   if (RAM_BANK_W < 1 || RAM_BANK_W > 2) begin : g_bad_ram_w
      $error("RAM_BANK_W must lie in 1..2");
   end

   logic [ROM_BANK_W-1:0] rom_bank;
   logic [RAM_BANK_W-1:0] ram_bank;
   win_kind_e             kind;
   logic [CLK_IDX_W-1:0]  clk_idx;
   logic                  access_en;
   logic                  latched;
   logic                  latch_go;
   logic                  clk_wr;
   clk_view_t             live_view;
   clk_view_t             snap_view;

   cbr_ctl #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .wr        (bus_wr),
      .rom_bank  (rom_bank),
      .ram_bank  (ram_bank),
      .kind      (kind),
      .clk_idx   (clk_idx),
      .access_en (access_en),
      .latched   (latched),
      .latch_go  (latch_go),
      .clk_wr    (clk_wr)
   );

   cbr_clock u_clock (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sec_tick),
      .clk_wr    (clk_wr),
      .wr_idx    (clk_idx),
      .wdata     (bus_wdata),
      .latch_go  (latch_go),
      .live_view (live_view),
      .snap_view (snap_view)
   );

   cbr_map #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_map (
      .addr      (bus_addr),
      .rd        (bus_rd),
      .wr        (bus_wr),
      .rom_bank  (rom_bank),
      .ram_bank  (ram_bank),
      .kind      (kind),
      .clk_idx   (clk_idx),
      .access_en (access_en),
      .latched   (latched),
      .live_view (live_view),
      .snap_view (snap_view),
      .rom_addr  (rom_addr),
      .ram_addr  (ram_addr),
      .ram_cs    (ram_cs),
      .ram_we    (ram_we),
      .rtc_hit   (rtc_hit),
      .rtc_rdata (rtc_rdata)
   );

endmodule

// File: tb/test_cart_bank_rtc.sv
module test_cart_bank_rtc;

   localparam int ROM_AW = 21;
   localparam int RAM_AW = 15;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [15:0]       bus_addr = 16'h0000;
   logic [7:0]        bus_wdata = 8'h00;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic              sec_tick = 1'b0;
   logic [ROM_AW-1:0] rom_addr;
   logic [RAM_AW-1:0] ram_addr;
   logic              ram_cs;
   logic              ram_we;
   logic              rtc_hit;
   logic [7:0]        rtc_rdata;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   always #4 clk = ~clk;

   cart_bank_rtc i_cart_bank_rtc (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .sec_tick(sec_tick),
      .rom_addr(rom_addr), .ram_addr(ram_addr), .ram_cs(ram_cs),
      .ram_we(ram_we), .rtc_hit(rtc_hit), .rtc_rdata(rtc_rdata)
   );

   // {write data, probe address, expected bank}
   localparam logic [30:0] ROM_VEC [6] = '{
      {8'h00, 16'h4000, 7'h01},
      {8'h05, 16'h7FFF, 7'h05},
      {8'h7F, 16'h5123, 7'h7F},
      {8'h80, 16'h4000, 7'h01},
      {8'h85, 16'h6ABC, 7'h05},
      {8'h2A, 16'h7001, 7'h2A}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_rd = 1'b0; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic peek(input logic [15:0] a);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #2;
   endtask

   task automatic tick();
      @(negedge clk);
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
   endtask

   task automatic clk_reg(input logic [7:0] sel, output logic [7:0] v);
      bus_write(16'h4000, sel);
      peek(16'hA000);
      v = rtc_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      peek(16'h4000);
      check("R12 reset rom bank", 32'(rom_addr), 32'h04000);
      peek(16'hA000);
      check("R12 reset no ram_cs", 32'(ram_cs), 0);
      check("R12 reset no rtc_hit", 32'(rtc_hit), 0);

      // R1/R2 table walk
      foreach (ROM_VEC[i]) begin
         logic [7:0]  d;
         logic [15:0] a;
         logic [6:0]  b;
         {d, a, b} = ROM_VEC[i];
         bus_write((i % 2 == 0) ? 16'h2000 : 16'h3FFF, d);
         peek(a);
         check("R1 R2 banked rom addr", 32'(rom_addr), 32'({b, a[13:0]}));
      end
      peek(16'h1234);
      check("R2 fixed window", 32'(rom_addr), 32'h01234);

      // R4/R5 RAM access
      peek(16'hA123);
      check("R5 disabled ram_cs", 32'(ram_cs), 0);
      bus_write(16'h0000, 8'h0A);
      bus_write(16'h4000, 8'h02);
      peek(16'hA123);
      check("R4 ram_cs on read", 32'(ram_cs), 1);
      check("R4 ram_addr", 32'(ram_addr), 32'h4123);
      check("R4 ram_we low on read", 32'(ram_we), 0);
      @(negedge clk);
      bus_rd = 1'b0; bus_addr = 16'hA010; bus_wdata = 8'h55; bus_wr = 1'b1;
      #2;
      check("R4 ram_we on write", 32'(ram_we), 1);
      check("R4 ram_addr on write", 32'(ram_addr), 32'h4010);
      @(negedge clk);
      bus_wr = 1'b0;

      // R3 rejected select values
      bus_write(16'h4000, 8'h05);
      bus_write(16'h5FFF, 8'h0D);
      peek(16'hA123);
      check("R3 bad select ignored", 32'(ram_addr), 32'h4123);
      check("R3 still ram", 32'(ram_cs), 1);

      // R5 enable nibble
      bus_write(16'h1000, 8'h3B);
      peek(16'hA123);
      check("R5 disable", 32'(ram_cs), 0);
      bus_write(16'h1FFF, 8'h5A);
      peek(16'hA123);
      check("R5 reenable nibble A", 32'(ram_cs), 1);

      // R3/R7/R8 clock access
      clk_reg(8'h08, v);
      check("R3 clock selected", 32'(rtc_hit), 1);
      check("R3 ram_cs off for clock", 32'(ram_cs), 0);
      check("R7 live sec zero", 32'(v), 0);
      bus_write(16'hA000, 8'h3B);
      peek(16'hA000);
      check("R8 sec written", 32'(rtc_rdata), 32'h3B);

      // R6/R7/R9 latch then tick
      bus_write(16'h6000, 8'h00);
      bus_write(16'h6000, 8'h01);
      tick();
      peek(16'hA000);
      check("R7 snapshot sec", 32'(rtc_rdata), 32'h3B);
      clk_reg(8'h09, v);
      check("R7 snapshot min", 32'(v), 0);
      bus_write(16'h7FFF, 8'h00);
      peek(16'hA000);
      check("R9 minute carry live", 32'(rtc_rdata), 1);
      clk_reg(8'h08, v);
      check("R9 sec wrap live", 32'(v), 0);

      // R6 edge rules
      bus_write(16'h6000, 8'h01);
      tick();
      bus_write(16'h6000, 8'h01);
      peek(16'hA000);
      check("R6 repeated 1 no copy", 32'(rtc_rdata), 0);
      bus_write(16'h6000, 8'h02);
      bus_write(16'h6000, 8'h01);
      peek(16'hA000);
      check("R6 2 then 1 no copy", 32'(rtc_rdata), 0);
      bus_write(16'h6000, 8'h00);
      bus_write(16'h6000, 8'h01);
      peek(16'hA000);
      check("R6 0 then 1 copies", 32'(rtc_rdata), 1);
      bus_write(16'h6000, 8'h00);

      // R10 halt
      bus_write(16'h4000, 8'h0C);
      bus_write(16'hA000, 8'h40);
      peek(16'hA000);
      check("R10 halt flag reads", 32'(rtc_rdata), 32'h40);
      tick();
      tick();
      clk_reg(8'h08, v);
      check("R10 halted sec", 32'(v), 1);
      bus_write(16'h4000, 8'h0C);
      bus_write(16'hA000, 8'h00);
      tick();
      clk_reg(8'h08, v);
      check("R10 resumed sec", 32'(v), 2);

      // R9 full cascade
      bus_write(16'h4000, 8'h0A); bus_write(16'hA000, 8'h17);
      bus_write(16'h4000, 8'h09); bus_write(16'hA000, 8'h3B);
      bus_write(16'h4000, 8'h08); bus_write(16'hA000, 8'h3B);
      bus_write(16'h4000, 8'h0B); bus_write(16'hA000, 8'h10);
      tick();
      clk_reg(8'h0B, v); check("R9 day inc", 32'(v), 32'h11);
      clk_reg(8'h0A, v); check("R9 hour wrap", 32'(v), 0);
      clk_reg(8'h09, v); check("R9 min wrap", 32'(v), 0);

      // R11 day bit 8 then overflow
      bus_write(16'h4000, 8'h0A); bus_write(16'hA000, 8'h17);
      bus_write(16'h4000, 8'h09); bus_write(16'hA000, 8'h3B);
      bus_write(16'h4000, 8'h08); bus_write(16'hA000, 8'h3B);
      bus_write(16'h4000, 8'h0B); bus_write(16'hA000, 8'hFF);
      tick();
      clk_reg(8'h0C, v); check("R11 day bit8 set", 32'(v), 32'h01);
      bus_write(16'h4000, 8'h0A); bus_write(16'hA000, 8'h17);
      bus_write(16'h4000, 8'h09); bus_write(16'hA000, 8'h3B);
      bus_write(16'h4000, 8'h08); bus_write(16'hA000, 8'h3B);
      bus_write(16'h4000, 8'h0B); bus_write(16'hA000, 8'hFF);
      tick();
      clk_reg(8'h0C, v); check("R11 wrap carry", 32'(v), 32'h80);
      clk_reg(8'h0B, v); check("R11 wrap day low", 32'(v), 0);
      tick();
      clk_reg(8'h0C, v); check("R11 carry sticky", 32'(v), 32'h80);
      bus_write(16'hA000, 8'h00);
      peek(16'hA000);
      check("R11 carry cleared", 32'(rtc_rdata), 0);

      // R5 clock write blocked while disabled
      clk_reg(8'h08, v);
      check("R5 sec before", 32'(v), 1);
      bus_write(16'h0000, 8'h00);
      bus_write(16'hA000, 8'h22);
      peek(16'hA000);
      check("R5 disabled rtc_hit", 32'(rtc_hit), 0);
      check("R5 disabled rdata", 32'(rtc_rdata), 0);
      bus_write(16'h0000, 8'h0A);
      peek(16'hA000);
      check("R5 write ignored", 32'(rtc_rdata), 1);

      // R12 reset mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      peek(16'h4000);
      check("R12 bank after reset", 32'(rom_addr), 32'h04000);
      peek(16'hA000);
      check("R12 disabled after reset", 32'(rtc_hit), 0);
      bus_write(16'h0000, 8'h0A);
      peek(16'hA456);
      check("R12 ram bank 0", 32'(ram_addr), 32'h0456);
      clk_reg(8'h08, v);
      check("R12 time cleared", 32'(v), 0);

      finish_run();
   end

endmodule